// File: doc/BRIEF.md
# SRAM ECC Fault Injection Unit

This block sits on the write path between an SRAM controller's SEC-DED encoder and the array write port. Software uses it to corrupt stored codewords on purpose, so that the double-error detection path can be exercised. When injection applies to a write, the block inverts one chosen data bit and the overall odd-parity check bit of the outgoing codeword. The result is an uncorrectable two-bit error. The corruption is purely combinational, so it adds no write latency.

A 16-bit control register holds a continuous-force enable, a one-shot force enable and a 7-bit target bit position. Software accesses it as two bytes over a small address/write-enable/byte-data bus. The continuous mode corrupts every write. The one-shot mode corrupts only the first qualifying write, and it fires again only after software clears the enable and sets it once more.

A three-state machine tracks the one-shot. In `OS_IDLE` the enable is clear, or has just been set and the shot has not yet been taken. In `OS_ARMED` the enable has been held high and the shot is still pending. In `OS_SPENT` the shot has been taken.

Its transitions are:
- IDLE→ARMED: the enable is high and no shot is taken.
- IDLE→SPENT and ARMED→SPENT: a shot is taken.
- ARMED→IDLE and SPENT→IDLE: the enable is cleared.

The shot counts as available whenever the enable is high and the state is not `OS_SPENT`.

Top module: `ecc_inject_unit`

## Requirements
- R1: The register has two byte addresses. The control byte is at `REG_OFS`: bit 1 is the continuous enable, bit 0 is the one-shot enable, and bits 7:2 read as zero. The target byte is at `REG_OFS+1`: bits 6:0 hold the target position and bit 7 reads as zero. Any other address reads zero, and writes to it change nothing.
- R2: After reset, both enables and the target are zero and no write is corrupted.
- R3: While the continuous enable is set and the target is below 64, every write (`wr_en`=1) leaves the block with data bit [target] inverted and check bit 7 inverted.
- R4: A corrupted codeword differs from the encoder's codeword in exactly two bits.
- R5: With one-shot mode selected, the first write in a cycle after the register write that sets the enable is corrupted. A write in the same cycle as that register write is not corrupted.
- R6: After the one-shot has fired, later writes pass unchanged while the enable stays set. Clearing the enable and setting it again re-arms the shot.
- R7: A target of 64 or above disables corruption in every mode. Such a write does not consume a pending one-shot.
- R8: If both enables are set (an illegal setting), continuous mode governs and a pending one-shot is left unconsumed.
- R9: When `wr_en` is low, the outgoing codeword equals the incoming one in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte (combinational) |
| wr_en | input | 1 | SRAM write strobe from controller |
| enc_data | input | DATA_W | Data word from ECC encoder |
| enc_check | input | CHK_W | Check bits from ECC encoder |
| mem_data | output | DATA_W | Data word to array |
| mem_check | output | CHK_W | Check bits to array |

## Verification
The bench builds the block with its defaults: a 64-bit data word, 8 check bits and an 8-bit address with the register at 0x10. With these defaults the 7-bit target field spans codes 64 to 127 that lie beyond the data word, so the no-injection range is reachable from ordinary writes. Random register writes also hit neighbouring addresses and the illegal both-enables setting. Together with directed re-arm and same-cycle cases, this walks every transition of the one-shot machine.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
    localparam int TGT_W    = 7;
    localparam int BIT_CONT = 1;
    localparam int BIT_OS   = 0;

    typedef enum logic [1:0] {
        OS_IDLE  = 2'd0,
        OS_ARMED = 2'd1,
        OS_SPENT = 2'd2
    } os_state_e;
endpackage

// File: rtl/inj_ctrl_reg.sv
module inj_ctrl_reg
    import ecc_inj_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              cont_en,
    output logic              os_en,
    output logic [TGT_W-1:0]  tgt
);
    localparam logic [ADDR_W-1:0] OFS_TGT = REG_OFS + 1'b1;

    logic hit_ctl, hit_tgt;
    assign hit_ctl = (reg_addr == REG_OFS);
    assign hit_tgt = (reg_addr == OFS_TGT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_en <= 1'b0;
            os_en   <= 1'b0;
            tgt     <= '0;
        end else if (reg_we) begin
            if (hit_ctl) begin
                cont_en <= reg_wdata[BIT_CONT];
                os_en   <= reg_wdata[BIT_OS];
            end
            if (hit_tgt) begin
                tgt <= reg_wdata[TGT_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (hit_ctl) begin
            reg_rdata[BIT_CONT] = cont_en;
            reg_rdata[BIT_OS]   = os_en;
        end else if (hit_tgt) begin
            reg_rdata[TGT_W-1:0] = tgt;
        end
    end

    // R1: reserved bits of the control byte read as zero
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctl |-> (reg_rdata[7:2] == 6'd0));

    // R1: writes to foreign addresses leave the register unchanged
    a_r1_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !hit_ctl && !hit_tgt) |=> ($stable(cont_en) && $stable(os_en) && $stable(tgt)));
endmodule

// File: rtl/inj_oneshot_fsm.sv
module inj_oneshot_fsm
    import ecc_inj_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic os_en,
    input  logic wr_hit,
    output logic os_active,
    output logic os_fire
);
    os_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OS_IDLE: begin
                if (os_en && wr_hit) state_nx = OS_SPENT;
                else if (os_en)      state_nx = OS_ARMED;
            end
            OS_ARMED: begin
                if (!os_en)      state_nx = OS_IDLE;
                else if (wr_hit) state_nx = OS_SPENT;
            end
            OS_SPENT: begin
                if (!os_en) state_nx = OS_IDLE;
            end
            default: state_nx = OS_IDLE;
        endcase
    end

    always_comb begin
        os_active = 1'b0;
        unique case (state)
            OS_IDLE:  os_active = os_en;
            OS_ARMED: os_active = os_en;
            OS_SPENT: os_active = 1'b0;
            default:  os_active = 1'b0;
        endcase
    end

    assign os_fire = os_active && wr_hit;

    // R6: a shot never fires on two consecutive cycles
    a_r6_oneshot_once: assert property (@(posedge clk) disable iff (!rst_n)
        os_fire |=> !os_fire);

    // R6: once spent, the machine stays spent while the enable is held
    a_r6_spent_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (os_fire && os_en) |=> !os_active);
endmodule

// File: rtl/inj_corrupt.sv
module inj_corrupt #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int POS_W  = 7
) (
    input  logic              inject,
    input  logic [POS_W-1:0]  tgt,
    input  logic [DATA_W-1:0] enc_data,
    input  logic [CHK_W-1:0]  enc_check,
    output logic [DATA_W-1:0] mem_data,
    output logic [CHK_W-1:0]  mem_check
);
    localparam int PAR_IDX = CHK_W - 1;

    logic [DATA_W-1:0] flip;

    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        assign flip[i] = inject && (tgt == POS_W'(i));
    end

    always_comb begin
        mem_data           = enc_data ^ flip;
        mem_check          = enc_check;
        mem_check[PAR_IDX] = enc_check[PAR_IDX] ^ inject;
    end
endmodule

// File: rtl/ecc_inject_unit.sv
module ecc_inject_unit
    import ecc_inj_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] enc_data,
    input  logic [CHK_W-1:0]  enc_check,
    output logic [DATA_W-1:0] mem_data,
    output logic [CHK_W-1:0]  mem_check
);
    logic             cont_en, os_en, os_active, os_fire;
    logic [TGT_W-1:0] tgt;
    logic             tgt_ok, wr_hit, inject;

    inj_ctrl_reg #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_reg (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cont_en(cont_en), .os_en(os_en), .tgt(tgt)
    );

    // target must land inside the data word; continuous mode overrides one-shot
    assign tgt_ok = ({25'd0, tgt} < DATA_W);
    assign wr_hit = wr_en && tgt_ok && !cont_en;

    inj_oneshot_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .os_en(os_en), .wr_hit(wr_hit),
        .os_active(os_active), .os_fire(os_fire)
    );

    assign inject = (wr_en && tgt_ok && cont_en) || os_fire;

    inj_corrupt #(.DATA_W(DATA_W), .CHK_W(CHK_W), .POS_W(TGT_W)) u_cor (
        .inject(inject), .tgt(tgt), .enc_data(enc_data), .enc_check(enc_check),
        .mem_data(mem_data), .mem_check(mem_check)
    );

    // R4: a corrupted codeword differs in exactly two bits
    a_r4_two_bits: assert property (@(posedge clk) disable iff (!rst_n)
        inject |-> ($countones({mem_data ^ enc_data, mem_check ^ enc_check}) == 2));

    // R9: no write, no change
    a_r9_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> ((mem_data == enc_data) && (mem_check == enc_check)));

    // R7: out-of-range target never corrupts
    a_r7_oob_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_ok |-> ((mem_data == enc_data) && (mem_check == enc_check)));

    // R3: continuous mode with a valid target corrupts every write
    a_r3_cont_every: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cont_en && tgt_ok) |-> (mem_check[CHK_W-1] != enc_check[CHK_W-1]));
endmodule

// File: tb/sim_ecc_inject_unit.sv
module sim_ecc_inject_unit;
    localparam logic [7:0] OFS = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        wr_en = 1'b0;
    logic [63:0] enc_data = 64'd0;
    logic [7:0]  enc_check = 8'd0;
    logic [63:0] mem_data;
    logic [7:0]  mem_check;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the register and one-shot
    bit       m_cont = 0, m_os = 0, m_armed = 0;
    bit [6:0] m_tgt = 0;

    always #5 clk = ~clk;

    ecc_inject_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_en(wr_en),
        .enc_data(enc_data), .enc_check(enc_check),
        .mem_data(mem_data), .mem_check(mem_check)
    );

    task automatic chk(input string rq, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic bit m_inject();
        return (m_tgt < 64) && (m_cont || (m_os && m_armed));
    endfunction

    function automatic logic [71:0] exp_word(input logic [63:0] d, input logic [7:0] c, input bit inj);
        logic [63:0] dd = d;
        logic [7:0]  cc = c;
        if (inj) begin
            dd[m_tgt[5:0]] = ~dd[m_tgt[5:0]];
            cc[7] = ~cc[7];
        end
        return {dd, cc};
    endfunction

    task automatic model_reg(input logic [7:0] a, input logic [7:0] d);
        if (a == OFS) begin
            if (d[0] && !m_os) m_armed = 1;
            if (!d[0]) m_armed = 0;
            m_cont = d[1];
            m_os = d[0];
            if (m_cont && m_os) $display("NOTE: illegal both-enables setting written");
        end else if (a == OFS + 8'd1) begin
            m_tgt = d[6:0];
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
        model_reg(a, d);
    endtask

    task automatic reg_rd(input string rq, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a; #1;
        chk(rq, {64'd0, reg_rdata}, {64'd0, exp});
    endtask

    task automatic mem_wr(input string rq, input logic [63:0] d, input logic [7:0] c);
        bit inj;
        @(negedge clk);
        enc_data = d; enc_check = c; wr_en = 1'b1; #1;
        inj = m_inject();
        chk(rq, {mem_data, mem_check}, exp_word(d, c, inj));
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (inj && !m_cont && m_os) m_armed = 0;
    endtask

    task automatic idle_chk(input string rq, input logic [63:0] d, input logic [7:0] c);
        @(negedge clk);
        enc_data = d; enc_check = c; wr_en = 1'b0; #1;
        chk(rq, {mem_data, mem_check}, {d, c});
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: reset state
        reg_rd("R2 ctl reset", OFS, 8'h00);
        reg_rd("R2 tgt reset", OFS + 8'd1, 8'h00);
        mem_wr("R2 no inject after reset", 64'hDEAD_BEEF_0123_4567, 8'h5A);

        // R1: layout, reserved bits, foreign addresses
        reg_wr(OFS, 8'hFC);
        reg_rd("R1 reserved ctl bits zero", OFS, 8'h00);
        reg_wr(OFS + 8'd1, 8'hA5);
        reg_rd("R1 tgt bit7 zero", OFS + 8'd1, 8'h25);
        reg_wr(OFS + 8'd2, 8'hFF);
        reg_wr(OFS - 8'd1, 8'hFF);
        reg_rd("R1 foreign write ignored ctl", OFS, 8'h00);
        reg_rd("R1 foreign write ignored tgt", OFS + 8'd1, 8'h25);
        reg_rd("R1 foreign addr reads zero", OFS + 8'd2, 8'h00);

        // R3/R4: continuous mode, bit 0 and bit 63
        reg_wr(OFS + 8'd1, 8'd0);
        reg_wr(OFS, 8'h02);
        reg_rd("R1 cont readback", OFS, 8'h02);
        mem_wr("R3 cont bit0 w1", 64'h0, 8'h00);
        mem_wr("R3 cont bit0 w2", 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
        reg_wr(OFS + 8'd1, 8'd63);
        mem_wr("R4 cont bit63", rnd64(), 8'h3C);
        idle_chk("R9 idle passthrough in cont", rnd64(), 8'hC3);

        // R7: target 64 and 127
        reg_wr(OFS + 8'd1, 8'd64);
        mem_wr("R7 target 64 no inject", rnd64(), 8'h81);
        reg_wr(OFS + 8'd1, 8'd127);
        mem_wr("R7 target 127 no inject", rnd64(), 8'h18);
        reg_wr(OFS, 8'h00);

        // R5: one-shot, write in same cycle as enable set is not corrupted
        reg_wr(OFS + 8'd1, 8'd17);
        @(negedge clk);
        reg_addr = OFS; reg_wdata = 8'h01; reg_we = 1'b1;
        enc_data = 64'h1234; enc_check = 8'h00; wr_en = 1'b1; #1;
        chk("R5 same-cycle write untouched", {mem_data, mem_check}, {64'h1234, 8'h00});
        @(posedge clk); #1;
        reg_we = 1'b0; wr_en = 1'b0;
        model_reg(OFS, 8'h01);
        mem_wr("R5 first write corrupted", 64'h1234, 8'h00);
        mem_wr("R6 second write clean", 64'h1234, 8'h00);
        mem_wr("R6 third write clean", rnd64(), 8'h77);

        // R6: re-arm requires clear then set
        reg_wr(OFS, 8'h01);
        mem_wr("R6 rewrite while set no rearm", rnd64(), 8'h11);
        reg_wr(OFS, 8'h00);
        reg_wr(OFS, 8'h01);
        mem_wr("R6 rearmed fires", rnd64(), 8'h22);
        mem_wr("R6 after rearm clean", rnd64(), 8'h33);

        // R7: out-of-range write keeps one-shot pending
        reg_wr(OFS, 8'h00);
        reg_wr(OFS, 8'h01);
        reg_wr(OFS + 8'd1, 8'd64);
        mem_wr("R7 oob keeps arm", rnd64(), 8'h44);
        reg_wr(OFS + 8'd1, 8'd5);
        mem_wr("R7 arm still pending fires", rnd64(), 8'h55);

        // R8: both set, continuous wins, shot left pending
        reg_wr(OFS, 8'h00);
        reg_wr(OFS, 8'h03);
        mem_wr("R8 both set w1", rnd64(), 8'h66);
        mem_wr("R8 both set w2", rnd64(), 8'h66);
        reg_wr(OFS, 8'h01);
        mem_wr("R8 shot still pending", rnd64(), 8'h99);
        mem_wr("R8 shot then spent", rnd64(), 8'h99);

        // random mix
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 9);
            if (op < 2) begin
                bit [7:0] d = 8'($urandom_range(0, 3));
                if ($urandom_range(0, 4) == 0) d = 8'($urandom());
                reg_wr(OFS, d);
            end else if (op < 4) begin
                reg_wr(OFS + 8'd1, 8'($urandom_range(0, 79)));
            end else if (op == 4) begin
                reg_wr(8'($urandom()), 8'($urandom()));
            end else if (op == 5) begin
                idle_chk("R9 random idle", rnd64(), 8'($urandom()));
            end else begin
                mem_wr("R3/R5/R6/R7 random write", rnd64(), 8'($urandom()));
            end
        end
        reg_rd("R1 final ctl readback", OFS, {6'd0, m_cont, m_os});
        reg_rd("R1 final tgt readback", OFS + 8'd1, {1'b0, m_tgt});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule